// File: doc/BRIEF.md
# Chained descriptor DMA engine

This block is the internal DMA engine of a storage-card host controller. Software builds a list of four-word descriptors in memory, writes the address of the first one to a base register, and sets two enable bits. The engine then walks the list. For each descriptor it moves whole 32-bit words between the memory buffer the descriptor names and the data FIFO that faces the card. It hands the descriptor back to software by rewriting its flags word with the ownership bit cleared. The walk ends at the descriptor marked last, or at one that software does not own.

A descriptor holds, at increasing word offsets, a flags word, a byte count, a buffer address and a next-descriptor address. The flags word uses bit 31 for ownership, bit 4 for chained mode, bit 3 for the first segment and bit 2 for the last segment. All other flag bits pass through unchanged. Software splits a transfer into one descriptor for each group of up to eight blocks, and the final descriptor covers the remainder. The memory port carries single-beat word accesses: a request is held until `mem_ready`, and read data is valid in the ready cycle. The FIFOs are first-word fall-through.

Control registers are selected by `reg_addr`:
- Address 0 is control. Bit 0 is DMA enable, bit 1 is descriptor-engine enable, and bit 2 is the direction (1 = transmit from memory to the FIFO, 0 = receive). Bit 31 reads as busy.
- Address 1 is the descriptor base.
- Address 2 is status. Bit 0 is receive complete, bit 1 is transmit complete, and bit 2 is descriptor unavailable. Writing a one to a bit clears it.

Top module: `chain_dma`

## Requirements
- R1: After reset the status register reads 0, busy and `irq` are 0, and no memory request is made.
- R2: A write to address 0 with bits 0 and 1 set, while idle, starts a walk. The engine reads the four descriptor words at the base, base+4, base+8 and base+12, in that order. The two low address bits of the base are ignored.
- R3: If the flags word read has bit 31 clear, the engine makes no further memory access, sets status bit 2 and returns to idle.
- R4: In transmit mode the engine reads count/4 consecutive words starting at the buffer address and pushes each into the transmit FIFO in order. It pushes only when the FIFO is not full.
- R5: In receive mode the engine pops count/4 words from the receive FIFO and writes them to consecutive buffer addresses. It pops only when the FIFO is not empty.
- R6: After the data of a descriptor has moved, the engine writes the flags word back to the descriptor address with bit 31 cleared and every other bit kept.
- R7: If a processed descriptor is not last, the next one is read from the address in word 3 when flag bit 4 is set, and from the current address plus 16 when bit 4 is clear.
- R8: After the write-back of a descriptor with flag bit 2 set, the engine goes idle (busy reads 0). It sets status bit 1 for a transmit walk or bit 0 for a receive walk, and `irq` rises.
- R9: A status write clears exactly the bits written as one. `irq` is 1 while any status bit is set.
- R10: A descriptor with a byte count below 4 moves no data. It is still written back, and the walk continues from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 base, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Any status bit set |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| txf_push | output | 1 | Push a word into the transmit FIFO |
| txf_data | output | 32 | Word pushed |
| txf_full | input | 1 | Transmit FIFO full |
| rxf_pop | output | 1 | Pop a word from the receive FIFO |
| rxf_data | input | 32 | Head word of the receive FIFO |
| rxf_empty | input | 1 | Receive FIFO empty |

## Verification
A register write takes effect on the next clock edge. The busy bit therefore reads 1 from the sample after the start write.

Memory, FIFO push and FIFO pop handshakes complete on the edge where ready and request are both high, so the bench drives its random ready, full and empty values just after the falling edge. It then records the handshakes that the coming rising edge will complete, and applies their effects at the following falling edge.

Status bits, `irq` and the fall of busy all appear on the edge that completes the final write-back, or on the edge of the unowned flags read. The bench polls busy at falling edges and compares status, the access log, FIFO contents and written-back memory only once the engine has gone idle.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          txf_push,
  output logic [31:0]   txf_data,
  input  logic          txf_full,
  output logic          rxf_pop,
  input  logic [31:0]   rxf_data,
  input  logic          rxf_empty
);
  localparam int OWN = 31;
  localparam int CHN = 4;
  localparam int LST = 2;
  localparam int WW  = 30;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_WB} st_t;

  st_t          state;
  logic [1:0]   widx;
  logic [2:0]   ctl, sts;
  logic         dir_tx;
  logic [AW-1:0] base_r, cur, buf_a, nxt;
  logic [31:0]  flags, cnt;
  logic [WW-1:0] dw;

  logic fetch, xfer, wb, hs, go, unav, fin;
  logic [2:0] sts_clr, sts_set;

  assign fetch = (state == S_FETCH);
  assign xfer  = (state == S_XFER);
  assign wb    = (state == S_WB);
  assign go    = reg_wr && reg_addr == 2'd0 && reg_wdata[1:0] == 2'b11 && state == S_IDLE;

  assign mem_req   = fetch | wb | (xfer & (dir_tx ? !txf_full : !rxf_empty));
  assign mem_we    = wb | (xfer & !dir_tx);
  assign mem_addr  = fetch ? cur + AW'({widx, 2'b00}) :
                     wb    ? cur : buf_a + AW'({dw, 2'b00});
  assign mem_wdata = wb ? (flags & ~(32'd1 << OWN)) : rxf_data;
  assign hs        = mem_req & mem_ready;

  assign txf_push = xfer & dir_tx & hs;
  assign txf_data = mem_rdata;
  assign rxf_pop  = xfer & !dir_tx & hs;

  assign unav    = fetch && mem_ready && widx == 2'd0 && !mem_rdata[OWN];
  assign fin     = wb && mem_ready && flags[LST];
  assign sts_set = {unav, fin & dir_tx, fin & !dir_tx};
  assign sts_clr = (reg_wr && reg_addr == 2'd2) ? reg_wdata[2:0] : 3'b000;
  assign irq     = |sts;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {state != S_IDLE, 28'd0, ctl};
      2'd1:    reg_rdata = 32'(base_r);
      2'd2:    reg_rdata = {29'd0, sts};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      widx   <= '0;
      ctl    <= '0;
      sts    <= '0;
      dir_tx <= 1'b0;
      base_r <= '0;
      cur    <= '0;
      buf_a  <= '0;
      nxt    <= '0;
      flags  <= '0;
      cnt    <= '0;
      dw     <= '0;
    end else begin
      sts <= (sts & ~sts_clr) | sts_set;
      if (reg_wr && reg_addr == 2'd0) ctl <= reg_wdata[2:0];
      if (reg_wr && reg_addr == 2'd1) base_r <= {reg_wdata[AW-1:2], 2'b00};
      case (state)
        S_IDLE: if (go) begin
          state  <= S_FETCH;
          cur    <= base_r;
          widx   <= '0;
          dir_tx <= reg_wdata[2];
        end
        S_FETCH: if (mem_ready) begin
          case (widx)
            2'd0: flags <= mem_rdata;
            2'd1: cnt   <= mem_rdata;
            2'd2: buf_a <= {mem_rdata[AW-1:2], 2'b00};
            default: nxt <= {mem_rdata[AW-1:2], 2'b00};
          endcase
          widx <= widx + 2'd1;
          if (unav) state <= S_IDLE;
          else if (widx == 2'd3) begin
            dw    <= '0;
            state <= (cnt[31:2] == '0) ? S_WB : S_XFER;
          end
        end
        S_XFER: if (hs) begin
          dw <= dw + WW'(1);
          if (dw + WW'(1) == cnt[31:2]) state <= S_WB;
        end
        default: if (mem_ready) begin
          if (flags[LST]) state <= S_IDLE;
          else begin
            cur   <= flags[CHN] ? nxt : cur + AW'(16);
            widx  <= '0;
            state <= S_FETCH;
          end
        end
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> !mem_req);

  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch && !mem_ready |=> mem_req && $stable(mem_addr));

  p_unavail_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> state == S_IDLE && $past(state) == S_FETCH);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts[0]) || $rose(sts[1])) |-> state == S_IDLE && $past(state) == S_WB);
endmodule

// File: tb/chain_dma_tb_top.sv
`timescale 1ns/1ps
module chain_dma_tb_top;
  localparam logic [31:0] F_OWN = 32'h8000_0000;
  localparam logic [31:0] F_CH  = 32'h0000_0010;
  localparam logic [31:0] F_FS  = 32'h0000_0008;
  localparam logic [31:0] F_LD  = 32'h0000_0004;

  logic clk = 0;
  logic rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_ready = 0;
  logic txf_push, rxf_pop;
  logic [31:0] txf_data;
  logic txf_full = 0;
  logic rxf_empty = 1;
  logic [31:0] rxf_head = 0;

  logic [31:0] mem [0:4095];
  bit          log_we[$];
  logic [31:0] log_ad[$];
  logic [31:0] pushed[$];
  logic [31:0] rxq[$];
  bit          exp_we[$];
  logic [31:0] exp_ad[$];
  logic [31:0] expq[$];

  bit pw, ppop;
  logic [31:0] pw_addr, pw_data;
  int nchk = 0;
  int nerr = 0;
  int cb[8];

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[13:2]];

  chain_dma #(.AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .txf_push(txf_push), .txf_data(txf_data), .txf_full(txf_full),
    .rxf_pop(rxf_pop), .rxf_data(rxf_head), .rxf_empty(rxf_empty));

  always @(negedge clk) begin
    if (pw) mem[pw_addr[13:2]] = pw_data;
    if (ppop && rxq.size() > 0) void'(rxq.pop_front());
    pw = 0;
    ppop = 0;
    mem_ready = ($urandom % 4) != 0;
    txf_full  = ($urandom % 5) == 0;
    rxf_empty = (rxq.size() == 0) || (($urandom % 5) == 0);
    rxf_head  = (rxq.size() > 0) ? rxq[0] : 32'd0;
    #1;
    if (rst_n && mem_req && mem_ready) begin
      log_we.push_back(mem_we);
      log_ad.push_back(mem_addr);
      if (mem_we) begin
        pw = 1;
        pw_addr = mem_addr;
        pw_data = mem_wdata;
      end
    end
    if (rst_n && txf_push) pushed.push_back(txf_data);
    if (rst_n && rxf_pop) ppop = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
    reg_addr = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin
      reg_read(2'd0, v);
      n++;
    end while (v[31] && n < 20000);
    chk("R8 busy cleared", {31'd0, v[31]}, 32'd0);
  endtask

  task automatic clear_logs();
    log_we.delete(); log_ad.delete(); pushed.delete();
    exp_we.delete(); exp_ad.delete(); expq.delete();
  endtask

  task automatic check_log(input string req);
    int bad = -1;
    chk({req, " access count"}, log_ad.size(), exp_ad.size());
    for (int i = 0; i < exp_ad.size() && i < log_ad.size(); i++)
      if (bad < 0 && (log_ad[i] !== exp_ad[i] || log_we[i] != exp_we[i])) bad = i;
    if (bad >= 0) chk({req, " access order"}, {log_we[bad], log_ad[bad][30:0]}, {exp_we[bad], exp_ad[bad][30:0]});
    else chk({req, " access order"}, 32'd0, 32'd0);
  endtask

  task automatic run_case(input bit tx, input int n, input bit chain);
    logic [31:0] da[8], ba[8], fl[8];
    logic [31:0] v;
    clear_logs();
    for (int i = 0; i < n; i++) begin
      da[i] = chain ? (32'h800 - i * 32'h60) : (32'h200 + i * 16);
      ba[i] = 32'h1000 + i * 32'h200;
    end
    for (int i = 0; i < n; i++) begin
      fl[i] = F_OWN | (chain ? F_CH : 0) | (i == 0 ? F_FS : 0) |
              (i == n - 1 ? F_LD : 0) | (($urandom & 32'hF) << 8);
      mem[da[i][13:2]]     = fl[i];
      mem[da[i][13:2] + 1] = cb[i];
      mem[da[i][13:2] + 2] = ba[i];
      mem[da[i][13:2] + 3] = chain ? ((i < n - 1) ? da[i + 1] : 32'h0) : 32'hDEAD_0000;
      for (int k = 0; k < 4; k++) begin
        exp_we.push_back(0); exp_ad.push_back(da[i] + k * 4);
      end
      for (int k = 0; k < cb[i] / 4; k++) begin
        v = $urandom;
        if (tx) mem[ba[i][13:2] + k] = v;
        else begin
          mem[ba[i][13:2] + k] = 32'h0;
          rxq.push_back(v);
        end
        expq.push_back(v);
        exp_we.push_back(!tx); exp_ad.push_back(ba[i] + k * 4);
      end
      exp_we.push_back(1); exp_ad.push_back(da[i]);
    end
    reg_write(2'd1, da[0] | 32'h3);
    reg_write(2'd2, 32'h7);
    reg_write(2'd0, {29'd0, tx, 2'b11});
    wait_idle();
    check_log("R2 R7 R10");
    if (tx) begin
      chk("R4 pushed count", pushed.size(), expq.size());
      for (int i = 0; i < expq.size() && i < pushed.size(); i++)
        chk("R4 pushed word", pushed[i], expq[i]);
    end else begin
      chk("R5 rx fifo drained", rxq.size(), 0);
      for (int i = 0, j = 0; i < n; i++)
        for (int k = 0; k < cb[i] / 4; k++) begin
          chk("R5 buffer word", mem[ba[i][13:2] + k], expq[j]);
          j++;
        end
    end
    for (int i = 0; i < n; i++)
      chk("R6 flags write-back", mem[da[i][13:2]], fl[i] & ~F_OWN);
    reg_read(2'd2, v);
    chk("R8 done status", v, tx ? 32'd2 : 32'd1);
    chk("R8 irq", {31'd0, irq}, 32'd1);
    reg_write(2'd2, 32'h3);
    reg_read(2'd2, v);
    chk("R9 status cleared", v, 32'd0);
    chk("R9 irq low", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    reg_read(2'd2, v);
    chk("R1 status after reset", v, 32'd0);
    reg_read(2'd0, v);
    chk("R1 busy after reset", {31'd0, v[31]}, 32'd0);
    chk("R1 no request", {31'd0, mem_req}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    clear_logs();
    mem[32'h300 >> 2] = 32'h0000_0014;
    mem[(32'h300 >> 2) + 1] = 32'd64;
    reg_write(2'd1, 32'h300);
    reg_write(2'd0, 32'h3);
    wait_idle();
    exp_we.push_back(0); exp_ad.push_back(32'h300);
    check_log("R3");
    chk("R3 flags untouched", mem[32'h300 >> 2], 32'h0000_0014);
    reg_read(2'd2, v);
    chk("R3 unavailable status", v, 32'd4);
    reg_write(2'd2, 32'h3);
    reg_read(2'd2, v);
    chk("R9 unwritten bit kept", v, 32'd4);
    chk("R9 irq held", {31'd0, irq}, 32'd1);
    reg_write(2'd2, 32'h4);
    reg_read(2'd2, v);
    chk("R9 bit cleared", v, 32'd0);

    cb[0] = 128; cb[1] = 128; cb[2] = 48;
    run_case(1, 3, 1);

    cb[0] = 12; cb[1] = 0; cb[2] = 20;
    run_case(0, 3, 0);

    cb[0] = 2;
    run_case(1, 1, 0);

    for (int t = 0; t < 6; t++) begin
      int n = 1 + ($urandom % 4);
      for (int i = 0; i < n; i++) cb[i] = 4 * ($urandom % 17);
      run_case($urandom % 2, n, $urandom % 2);
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule